// File: doc/BRIEF.md
# Cross-Linked Dual-Node Serial Register Block

This block holds two copies of a byte-wide serial-port register set and wires the transmit side of each copy straight to the receive side of the other. The result works like a mailbox between two processors. Each node has its own register port for writes and combinational reads. A node loads a byte into its transmit register and then clears its transmit-empty flag. When the gating conditions hold, the byte moves to the other node's receive register in a single step. Nothing is shifted bit by bit.

After a byte moves, the status flags on both sides update. Each node has two interrupt outputs, one for transmit and one for receive. An interrupt appears as a one-cycle pulse that carries a priority level and a vector number. Both values are taken from the configuration registers of the node that receives the byte.

Top module: `duo_link_regs`

## Requirements
- R1: After reset each node reads 0xFF at offset 0 (rate) and offset 2 (transmit data), and 0x84 at offset 3 (status). All other offsets read 0x00, and all interrupt outputs are low.
- R2: A write of value w to status (offset 3) sets status to (old AND (w OR 0x06)) OR (w AND 0x01). Bit 7 (transmit empty) and bit 6 (receive full) can only be cleared this way, never set. Bits 1 and 2 never change after reset.
- R3: A byte moves only when all three of these hold: the sender's control bit 5 (transmit enable) is 1, the sender's status bit 7 is 0, and the receiver's control bit 4 (receive enable) is 1.
- R4: A byte is moved on the clock edge after the write that triggered it. On that edge the peer's receive data (offset 4) takes the sender's transmit data, the sender's status bit 7 is set, and the peer's status bit 6 is set.
- R5: The transfer conditions are tested only after two kinds of write: any status write, and a control write that changes bit 5 from 0 to 1. Writing transmit data, rewriting control while bit 5 is already 1, or enabling the peer's receiver does not start a transfer.
- R6: When a byte moves and the sender's control bit 7 is set, the sender's transmit interrupt pulses. Its level is bits 7:4 of the peer's priority register (offset 5) and its vector is bits 6:0 of the peer's offset 7.
- R7: When a byte moves and the receiver's control bit 6 is set, the receiver's receive interrupt pulses. Its level is bits 7:4 of the receiver's offset 5 and its vector is bits 6:0 of the receiver's offset 6.
- R8: Every interrupt pulse is exactly one cycle wide, and no interrupt fires when a transfer does not happen.
- R9: If both nodes become eligible in the same cycle, both bytes cross on the same edge and all four interrupts can fire together.
- R10: Offset 4 ignores writes. Offsets 8 to 15 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 2 | Write strobe, one bit per node |
| addr | input | 2x4 | Register offset per node (read and write) |
| wdata | input | 2x8 | Write data per node |
| rdata | output | 2x8 | Combinational read data per node |
| tx_irq | output | 2 | Transmit interrupt pulse per node |
| tx_irq_level | output | 2x4 | Transmit interrupt level per node |
| tx_irq_vec | output | 2x7 | Transmit interrupt vector per node |
| rx_irq | output | 2 | Receive interrupt pulse per node |
| rx_irq_level | output | 2x4 | Receive interrupt level per node |
| rx_irq_vec | output | 2x7 | Receive interrupt vector per node |

## Verification
A register write can be read back in the half cycle after the edge that takes it. A transfer and its interrupt pulses show up one edge after that, and each pulse has gone again one edge later. The bench drives inputs on the falling edge and samples on the falling edge. For every trigger it checks once right after the write, where the old receive data and quiet interrupts must still be seen, then once after the next edge for the moved byte and the pulses, then once more to confirm the pulses have dropped.

// File: rtl/duo_link_pkg.sv
`timescale 1ns/10ps
package duo_link_pkg;
    localparam int NODES = 2;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int LVL_W = 4;
    localparam int VEC_W = 7;

    typedef enum logic [AW-1:0] {
        RA_RATE  = 4'd0,
        RA_CTRL  = 4'd1,
        RA_TXD   = 4'd2,
        RA_STAT  = 4'd3,
        RA_RXD   = 4'd4,
        RA_PRIO  = 4'd5,
        RA_RXVEC = 4'd6,
        RA_TXVEC = 4'd7
    } reg_addr_e;

    localparam int CTL_TIE = 7;
    localparam int CTL_RIE = 6;
    localparam int CTL_TE  = 5;
    localparam int CTL_RE  = 4;
    localparam int ST_TDRE = 7;
    localparam int ST_RDRF = 6;

    localparam logic [DW-1:0] RATE_RST  = 8'hFF;
    localparam logic [DW-1:0] TXD_RST   = 8'hFF;
    localparam logic [DW-1:0] STAT_RST  = 8'h84;
    localparam logic [DW-1:0] STAT_KEEP = 8'h06;
    localparam logic [DW-1:0] STAT_FREE = 8'h01;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] stat;
        logic [DW-1:0] txd;
        logic [DW-1:0] rxd;
        logic [DW-1:0] prio;
        logic [DW-1:0] rxvec;
        logic [DW-1:0] txvec;
    } node_view_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } irq_t;

    function automatic logic [DW-1:0] stat_merge(input logic [DW-1:0] cur,
                                                 input logic [DW-1:0] wr);
        return (cur & (wr | STAT_KEEP)) | (wr & STAT_FREE);
    endfunction

    function automatic logic [LVL_W-1:0] prio_level(input logic [DW-1:0] prio);
        return prio[DW-1 -: LVL_W];
    endfunction
endpackage

// File: rtl/duo_link_node.sv
`timescale 1ns/10ps
module duo_link_node
    import duo_link_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          tx_done,
    input  logic          rx_load,
    input  logic [DW-1:0] rx_byte,
    output logic          check,
    output node_view_t    view
);
    logic [DW-1:0] rate_q, ctrl_q, txd_q, stat_q, rxd_q, prio_q, rxvec_q, txvec_q;
    logic [DW-1:0] stat_d;
    logic          wr_stat, te_rise, check_q;

    assign wr_stat = wr_en && (addr == RA_STAT);
    assign te_rise = wr_en && (addr == RA_CTRL) && !ctrl_q[CTL_TE] && wdata[CTL_TE];

    // Host write merge first, then transfer-driven flag sets win
    always_comb begin
        stat_d = wr_stat ? stat_merge(stat_q, wdata) : stat_q;
        if (tx_done) stat_d[ST_TDRE] = 1'b1;
        if (rx_load) stat_d[ST_RDRF] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= RATE_RST;
            ctrl_q  <= '0;
            txd_q   <= TXD_RST;
            stat_q  <= STAT_RST;
            rxd_q   <= '0;
            prio_q  <= '0;
            rxvec_q <= '0;
            txvec_q <= '0;
            check_q <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            check_q <= wr_stat || te_rise;
            if (rx_load) rxd_q <= rx_byte;
            if (wr_en) begin
                case (addr)
                    RA_RATE:  rate_q  <= wdata;
                    RA_CTRL:  ctrl_q  <= wdata;
                    RA_TXD:   txd_q   <= wdata;
                    RA_PRIO:  prio_q  <= wdata;
                    RA_RXVEC: rxvec_q <= wdata;
                    RA_TXVEC: txvec_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            RA_RATE:  rdata = rate_q;
            RA_CTRL:  rdata = ctrl_q;
            RA_TXD:   rdata = txd_q;
            RA_STAT:  rdata = stat_q;
            RA_RXD:   rdata = rxd_q;
            RA_PRIO:  rdata = prio_q;
            RA_RXVEC: rdata = rxvec_q;
            RA_TXVEC: rdata = txvec_q;
            default:  rdata = '0;
        endcase
    end

    assign check      = check_q;
    assign view.ctrl  = ctrl_q;
    assign view.stat  = stat_q;
    assign view.txd   = txd_q;
    assign view.rxd   = rxd_q;
    assign view.prio  = prio_q;
    assign view.rxvec = rxvec_q;
    assign view.txvec = txvec_q;
endmodule

// File: rtl/duo_link_xfer.sv
`timescale 1ns/10ps
module duo_link_xfer
    import duo_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       check,
    input  node_view_t own,
    input  node_view_t peer,
    output logic       fire,
    output irq_t       tx_irq,
    output irq_t       peer_rx_irq
);
    irq_t tx_q, rx_q;

    assign fire = check && own.ctrl[CTL_TE] && !own.stat[ST_TDRE] && peer.ctrl[CTL_RE];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q.valid <= fire && own.ctrl[CTL_TIE];
            rx_q.valid <= fire && peer.ctrl[CTL_RIE];
            if (fire) begin
                tx_q.level  <= prio_level(peer.prio);
                tx_q.vector <= peer.txvec[VEC_W-1:0];
                rx_q.level  <= prio_level(peer.prio);
                rx_q.vector <= peer.rxvec[VEC_W-1:0];
            end
        end
    end

    assign tx_irq      = tx_q;
    assign peer_rx_irq = rx_q;
endmodule

// File: rtl/duo_link_regs.sv
`timescale 1ns/10ps
module duo_link_regs
    import duo_link_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NODES-1:0]             wr_en,
    input  logic [NODES-1:0][AW-1:0]     addr,
    input  logic [NODES-1:0][DW-1:0]     wdata,
    output logic [NODES-1:0][DW-1:0]     rdata,
    output logic [NODES-1:0]             tx_irq,
    output logic [NODES-1:0][LVL_W-1:0]  tx_irq_level,
    output logic [NODES-1:0][VEC_W-1:0]  tx_irq_vec,
    output logic [NODES-1:0]             rx_irq,
    output logic [NODES-1:0][LVL_W-1:0]  rx_irq_level,
    output logic [NODES-1:0][VEC_W-1:0]  rx_irq_vec
);
    node_view_t       views  [NODES];
    irq_t             tx_pkt [NODES];
    irq_t             rx_pkt [NODES];
    logic [NODES-1:0] fire;
    logic [NODES-1:0] check;

    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int P = (n + 1) % NODES;

        duo_link_node u_node (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[n]),
            .addr    (addr[n]),
            .wdata   (wdata[n]),
            .rdata   (rdata[n]),
            .tx_done (fire[n]),
            .rx_load (fire[P]),
            .rx_byte (views[P].txd),
            .check   (check[n]),
            .view    (views[n])
        );

        duo_link_xfer u_xfer (
            .clk         (clk),
            .rst         (rst),
            .check       (check[n]),
            .own         (views[n]),
            .peer        (views[P]),
            .fire        (fire[n]),
            .tx_irq      (tx_pkt[n]),
            .peer_rx_irq (rx_pkt[P])
        );

        assign tx_irq[n]       = tx_pkt[n].valid;
        assign tx_irq_level[n] = tx_pkt[n].level;
        assign tx_irq_vec[n]   = tx_pkt[n].vector;
        assign rx_irq[n]       = rx_pkt[n].valid;
        assign rx_irq_level[n] = rx_pkt[n].level;
        assign rx_irq_vec[n]   = rx_pkt[n].vector;
    end
endmodule

// File: rtl/duo_link_chk.sv
`timescale 1ns/10ps
module duo_link_chk
    import duo_link_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NODES-1:0] tx_irq,
    input logic [NODES-1:0] rx_irq,
    input logic [NODES-1:0] fire,
    input node_view_t       views [NODES]
);
    for (genvar n = 0; n < NODES; n++) begin : g_chk
        localparam int P = (n + 1) % NODES;

        AST_TX_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) tx_irq[n] |=> !tx_irq[n]); // R8
        AST_RX_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) rx_irq[n] |=> !rx_irq[n]); // R8
        AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (rst) tx_irq[n] |-> views[n].stat[ST_TDRE]); // R6
        AST_RX_FULL_SET:  assert property (@(posedge clk) disable iff (rst) rx_irq[n] |-> views[n].stat[ST_RDRF]); // R7
        AST_BYTE_COPY:    assert property (@(posedge clk) disable iff (rst) fire[n] |=> views[P].rxd == $past(views[n].txd)); // R4
        AST_FIXED_BITS:   assert property (@(posedge clk) disable iff (rst) $stable(views[n].stat[2:1])); // R2
    end
endmodule

bind duo_link_regs duo_link_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tx_irq (tx_irq),
    .rx_irq (rx_irq),
    .fire   (fire),
    .views  (views)
);

// File: tb/duo_link_regs_bench.sv
`timescale 1ns/10ps
module duo_link_regs_bench;
    localparam logic [3:0] A_RATE = 4'h0, A_CTRL = 4'h1, A_TXD = 4'h2, A_STAT = 4'h3,
                           A_RXD = 4'h4, A_PRIO = 4'h5, A_RXV = 4'h6, A_TXV = 4'h7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      wr_en = '0;
    logic [1:0][3:0] addr = '0;
    logic [1:0][7:0] wdata = '0;
    logic [1:0][7:0] rdata;
    logic [1:0]      tx_irq, rx_irq;
    logic [1:0][3:0] tx_irq_level, rx_irq_level;
    logic [1:0][6:0] tx_irq_vec, rx_irq_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    duo_link_regs u_duo_link_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .tx_irq(tx_irq), .tx_irq_level(tx_irq_level), .tx_irq_vec(tx_irq_vec),
        .rx_irq(rx_irq), .rx_irq_level(rx_irq_level), .rx_irq_vec(rx_irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int n, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en[n] = 1'b1; addr[n] = a; wdata[n] = d;
        @(negedge clk);
        wr_en[n] = 1'b0;
    endtask

    task automatic wr2(input logic [3:0] a, input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk);
        wr_en = 2'b11; addr[0] = a; addr[1] = a; wdata[0] = d0; wdata[1] = d1;
        @(negedge clk);
        wr_en = 2'b00;
    endtask

    task automatic rd_chk(input string tag, input int n, input logic [3:0] a, input logic [7:0] exp);
        addr[n] = a;
        #0.1;
        chk(tag, rdata[n], exp);
    endtask

    task automatic irq_chk(input string tag, input logic [1:0] tx_exp, input logic [1:0] rx_exp);
        chk({tag, " tx_irq"}, tx_irq, tx_exp);
        chk({tag, " rx_irq"}, rx_irq, rx_exp);
    endtask

    task automatic t_reset;
        irq_chk("R1 R8 reset", 2'b00, 2'b00);
        for (int n = 0; n < 2; n++) begin
            for (int a = 0; a < 16; a++) begin
                logic [7:0] e;
                e = (a == 0 || a == 2) ? 8'hFF : (a == 3) ? 8'h84 : 8'h00;
                @(negedge clk);
                rd_chk((a >= 8) ? "R10 unmapped reset" : "R1 reset value", n, 4'(a), e);
            end
        end
    endtask

    task automatic t_status_write;
        wr(0, A_STAT, 8'hFF); rd_chk("R2 set free bit", 0, A_STAT, 8'h85);
        wr(0, A_STAT, 8'h00); rd_chk("R2 clear flags", 0, A_STAT, 8'h04);
        wr(0, A_STAT, 8'hFF); rd_chk("R2 no flag set", 0, A_STAT, 8'h05);
    endtask

    task automatic t_gating;
        wr(0, A_CTRL, 8'h20);
        @(negedge clk);
        rd_chk("R3 peer rx off rxd", 1, A_RXD, 8'h00);
        rd_chk("R3 peer rx off stat", 1, A_STAT, 8'h84);
        wr(1, A_CTRL, 8'h10);
        @(negedge clk);
        rd_chk("R5 peer enable no trigger", 0, A_STAT, 8'h05);
        wr(0, A_TXD, 8'h5A);
        @(negedge clk);
        rd_chk("R5 txd write no trigger", 1, A_RXD, 8'h00);
        wr(0, A_CTRL, 8'h20);
        @(negedge clk);
        rd_chk("R5 te rewrite no trigger", 1, A_RXD, 8'h00);
    endtask

    task automatic t_transfer;
        wr(0, A_STAT, 8'h01);
        rd_chk("R4 not before edge", 1, A_RXD, 8'h00);
        @(negedge clk);
        rd_chk("R4 peer rxd", 1, A_RXD, 8'h5A);
        rd_chk("R4 sender tdre", 0, A_STAT, 8'h85);
        rd_chk("R4 peer rdrf", 1, A_STAT, 8'hC4);
        irq_chk("R8 no enables", 2'b00, 2'b00);
    endtask

    task automatic t_blocked;
        wr(0, A_TXD, 8'h11);
        wr(0, A_STAT, 8'hFF);
        @(negedge clk);
        rd_chk("R3 tdre set blocks", 1, A_RXD, 8'h5A);
        wr(0, A_CTRL, 8'h00);
        wr(0, A_STAT, 8'h7F);
        @(negedge clk);
        rd_chk("R3 te off blocks", 1, A_RXD, 8'h5A);
        rd_chk("R3 te off stat", 0, A_STAT, 8'h05);
    endtask

    task automatic t_irq;
        wr(1, A_PRIO, 8'hB3); wr(1, A_RXV, 8'hC5); wr(1, A_TXV, 8'hFE);
        wr(0, A_PRIO, 8'h70); wr(0, A_RXV, 8'h12); wr(0, A_TXV, 8'h34);
        wr(1, A_CTRL, 8'h50);
        wr(0, A_CTRL, 8'hA0);
        irq_chk("R8 not yet", 2'b00, 2'b00);
        @(negedge clk);
        irq_chk("R6 R7 pulse", 2'b01, 2'b10);
        chk("R6 tx level", tx_irq_level[0], 4'hB);
        chk("R6 tx vector", tx_irq_vec[0], 7'h7E);
        chk("R7 rx level", rx_irq_level[1], 4'hB);
        chk("R7 rx vector", rx_irq_vec[1], 7'h45);
        rd_chk("R5 te rise moves byte", 1, A_RXD, 8'h11);
        @(negedge clk);
        irq_chk("R8 pulse ends", 2'b00, 2'b00);
    endtask

    task automatic t_both;
        wr(1, A_CTRL, 8'hF0);
        wr(0, A_CTRL, 8'hF0);
        @(negedge clk);
        irq_chk("R5 no trigger with tdre", 2'b00, 2'b00);
        wr(0, A_TXD, 8'hA1); wr(1, A_TXD, 8'hB2);
        wr2(A_STAT, 8'h00, 8'h00);
        @(negedge clk);
        irq_chk("R9 four pulses", 2'b11, 2'b11);
        chk("R9 tx0 level", tx_irq_level[0], 4'hB);
        chk("R9 tx0 vector", tx_irq_vec[0], 7'h7E);
        chk("R9 tx1 level", tx_irq_level[1], 4'h7);
        chk("R9 tx1 vector", tx_irq_vec[1], 7'h34);
        chk("R9 rx0 level", rx_irq_level[0], 4'h7);
        chk("R9 rx0 vector", rx_irq_vec[0], 7'h12);
        chk("R9 rx1 level", rx_irq_level[1], 4'hB);
        chk("R9 rx1 vector", rx_irq_vec[1], 7'h45);
        @(negedge clk);
        rd_chk("R9 rxd0", 0, A_RXD, 8'hB2);
        rd_chk("R9 rxd1", 1, A_RXD, 8'hA1);
        rd_chk("R9 stat0", 0, A_STAT, 8'hC4);
        rd_chk("R9 stat1", 1, A_STAT, 8'hC4);
        irq_chk("R8 both end", 2'b00, 2'b00);
    endtask

    task automatic t_readonly;
        wr(1, A_RXD, 8'h99);
        rd_chk("R10 rxd ignores write", 1, A_RXD, 8'hA1);
        wr(1, 4'hC, 8'h77);
        rd_chk("R10 unmapped ignores write", 1, 4'hC, 8'h00);
        wr(1, A_STAT, 8'hBF);
        @(negedge clk);
        rd_chk("R2 clear rdrf", 1, A_STAT, 8'h85);
        irq_chk("R8 no transfer no irq", 2'b00, 2'b00);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_status_write();
        t_gating();
        t_transfer();
        t_blocked();
        t_irq();
        t_both();
        t_readonly();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end
endmodule